// File: doc/BRIEF.md
# Scalar Double-Precision Predicated Compare Unit

This block compares two IEEE-754 binary64 values and turns the outcome into a 64-bit mask: all ones when the selected predicate holds, all zeros when it does not. The first comparand is the low 64 bits of a 128-bit destination operand. The second comparand is a separate 64-bit source. The mask replaces the low half of the destination value, and the upper half passes through untouched. The caller gets back the full 128-bit register image to write.

An 8-bit immediate picks the predicate. Only its three low bits matter. The eight predicates are equal, less-than and less-or-equal, their three negations, and the unordered and ordered tests. Any NaN comparand makes an ordered relation false and its negation true. Greater-than and greater-or-equal have no encoding of their own. The caller obtains them by swapping the comparands and using less-than or less-or-equal. Denormals are compared exactly, and the two zeros are treated as the same value.

The result is registered, so it appears one cycle after a valid request, together with an output valid strobe. Exception signalling and status flags are not produced.

Top module: `fp64_cmp_unit`

## Requirements
- R1: The comparison uses only `dst_in[63:0]` as the first comparand and `src_in` as the second. `dst_in[127:64]` never affects the mask.
- R2: `res_out[63:0]` is always either 64'h0 or 64'hFFFF_FFFF_FFFF_FFFF: all ones when the predicate holds, all zeros when it does not.
- R3: `res_out[127:64]` equals `dst_in[127:64]` of the request that produced the result.
- R4: Only `pred_imm[2:0]` selects the predicate. Bits 7 down to 3 have no effect on the result.
- R5: The predicate codes are 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, 7 ordered. Each compares the first comparand against the second (first < second for code 1).
- R6: A value is a NaN when bits [62:52] are all ones and bits [51:0] are nonzero; quiet and signalling NaNs behave alike. If either comparand is a NaN, codes 0, 1, 2 and 7 give all zeros, and codes 3, 4, 5 and 6 give all ones.
- R7: +0.0 and -0.0 compare equal: each is neither less than the other, and each is less-or-equal to the other.
- R8: Non-NaN values, including denormals and both infinities, are ordered by their exact real value.
- R9: A request presented with `in_vld` high at a rising edge appears on `res_out`, with `out_vld` high, after that edge. `out_vld` is low in the cycle after an edge where `in_vld` was low, and `res_out` then keeps its last value.
- R10: A synchronous active-high `rst` clears `out_vld` and `res_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| dst_in | input | 128 | Destination register value; low half is the first comparand |
| src_in | input | 64 | Second comparand |
| pred_imm | input | 8 | Predicate immediate; bits [2:0] used |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| res_out | output | 128 | Upper half of the destination followed by the 64-bit mask |

## Verification
The unit has no parameters, so the bench builds it exactly as it ships. Because the width is fixed at binary64, the bench can feed hand-picked bit patterns for zeros, infinities, denormals and both kinds of NaN. It draws random operands from a pool that mixes these specials with fully random words and with near-equal pairs, which makes the equal and sign-crossing cases common. Each request also carries random upper destination bits and random reserved immediate bits.

// File: rtl/fp64_cmp_unit.sv
module fp64_cmp_unit (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [127:0] dst_in,
  input  logic [63:0]  src_in,
  input  logic [7:0]   pred_imm,
  output logic         out_vld,
  output logic [127:0] res_out
);

  logic [63:0] opa, opb;
  logic        nan_a, nan_b, unord, zeros, same, a_lt_b, eq, lt, hit;

  assign opa = dst_in[63:0];
  assign opb = src_in;

  assign nan_a = (&opa[62:52]) && (|opa[51:0]);
  assign nan_b = (&opb[62:52]) && (|opb[51:0]);
  assign unord = nan_a | nan_b;
  assign zeros = (opa[62:0] == '0) && (opb[62:0] == '0);
  assign same  = (opa == opb) || zeros;

  always_comb begin
    if (opa[63] != opb[63])
      a_lt_b = opa[63];
    else if (opa[63])
      a_lt_b = opa[62:0] > opb[62:0];
    else
      a_lt_b = opa[62:0] < opb[62:0];
  end

  assign eq = !unord && same;
  assign lt = !unord && !zeros && a_lt_b;

  always_comb begin
    case (pred_imm[2:0])
      3'd0:    hit = eq;
      3'd1:    hit = lt;
      3'd2:    hit = lt | eq;
      3'd3:    hit = unord;
      3'd4:    hit = !eq;
      3'd5:    hit = !lt;
      3'd6:    hit = !(lt | eq);
      default: hit = !unord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      res_out <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) res_out <= {dst_in[127:64], {64{hit}}};
    end
  end

  AST_MASK_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (res_out[63:0] == '0) || (res_out[63:0] == '1)); // R2

  AST_HIGH_PASS: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> res_out[127:64] == $past(dst_in[127:64])); // R3

  AST_NAN_ORDERED_FALSE: assert property (@(posedge clk) disable iff (rst)
    (in_vld && unord && (pred_imm[2:0] == 3'd0 || pred_imm[2:0] == 3'd7))
      |=> res_out[63:0] == '0); // R6

  AST_NAN_NEGATED_TRUE: assert property (@(posedge clk) disable iff (rst)
    (in_vld && unord && (pred_imm[2:0] == 3'd4 || pred_imm[2:0] == 3'd3))
      |=> res_out[63:0] == '1); // R6

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_vld == $past(in_vld)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_vld && !$past(rst) |-> $stable(res_out)); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_vld && res_out == '0); // R10

endmodule

// File: tb/sim_fp64_cmp_unit.sv
module sim_fp64_cmp_unit;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [127:0] dst_in = '0;
  logic [63:0]  src_in = '0;
  logic [7:0]   pred_imm = '0;
  logic         out_vld;
  logic [127:0] res_out;

  int n_chk = 0;
  int n_bad = 0;

  fp64_cmp_unit u0 (.clk, .rst, .in_vld, .dst_in, .src_in, .pred_imm, .out_vld, .res_out);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic bit ref_hit(input logic [63:0] a, input logic [63:0] b, input logic [2:0] p);
    real ra, rb;
    bit un, e, l;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    un = is_nan(a) || is_nan(b);
    e  = !un && (ra == rb);
    l  = !un && (ra < rb);
    case (p)
      3'd0: return e;
      3'd1: return l;
      3'd2: return l || e;
      3'd3: return un;
      3'd4: return !e;
      3'd5: return !l;
      3'd6: return !(l || e);
      default: return !un;
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [127:0] d, input logic [63:0] s, input logic [7:0] imm);
    logic [127:0] exp;
    @(negedge clk);
    in_vld = 1'b1; dst_in = d; src_in = s; pred_imm = imm;
    exp = {d[127:64], {64{ref_hit(d[63:0], s, imm[2:0])}}};
    @(negedge clk);
    in_vld = 1'b0; dst_in = ~d; src_in = ~s;
    check({req, " vld"}, {127'd0, out_vld}, 128'd1);
    check(req, res_out, exp);
  endtask

  task automatic run_all(input string req, input logic [63:0] a, input logic [63:0] b);
    for (int p = 0; p < 8; p++) begin
      logic [127:0] d;
      d = {$urandom, $urandom, a};
      run_op(req, d, b, {$urandom_range(0, 31), 3'(p)});
    end
  endtask

  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'hFFF0_0000_0000_0001;
  localparam logic [63:0] DMIN = 64'h0000_0000_0000_0001;
  localparam logic [63:0] DMAX = 64'h000F_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] MONE = 64'hBFF0_0000_0000_0000;

  function automatic logic [63:0] pick();
    int k;
    k = $urandom_range(0, 13);
    case (k)
      0: return PZ;   1: return NZ;   2: return PINF; 3: return NINF;
      4: return QNAN; 5: return SNAN; 6: return DMIN; 7: return DMAX;
      8: return {$urandom_range(0,1), 11'd0, 20'($urandom), $urandom};
      9: return {$urandom_range(0,1), 11'h7FF, 20'($urandom), $urandom};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset", res_out, '0);
    check("R10 reset vld", {127'd0, out_vld}, '0);
    rst = 1'b0;

    run_all("R7 +0/-0", PZ, NZ);
    run_all("R7 -0/+0", NZ, PZ);
    run_all("R6 qnan", QNAN, ONE);
    run_all("R6 snan", ONE, SNAN);
    run_all("R6 nan/nan", SNAN, QNAN);
    run_all("R8 inf", NINF, PINF);
    run_all("R8 inf eq", PINF, PINF);
    run_all("R8 denorm", DMIN, DMAX);
    run_all("R8 denorm/zero", NZ, DMIN);
    run_all("R8 neg", MONE, 64'hBFF0_0000_0000_0001);
    run_all("R5 1/-1", ONE, MONE);
    run_op("R5 lt", {64'hDEAD, ONE}, PINF, 8'h01);
    run_op("R4 imm high bits", {64'h1, ONE}, ONE, 8'hF8);
    run_op("R4 imm bit3", {64'h2, ONE}, MONE, 8'h09);
    run_op("R1 high half ignored", {PINF, MONE}, ONE, 8'h01);
    run_op("R3 high pass", {64'hA5A5_5A5A_0F0F_F0F0, PZ}, PZ, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      a = pick();
      b = ($urandom_range(0, 4) == 0) ? a : pick();
      if ($urandom_range(0, 5) == 0) b = a ^ 64'(1 << $urandom_range(0, 63));
      run_op("R5 random", {$urandom, $urandom, a}, b, 8'($urandom));
    end

    @(negedge clk);
    begin
      logic [127:0] held;
      held = res_out;
      check("R9 idle vld", {127'd0, out_vld}, '0);
      repeat (3) @(negedge clk);
      check("R9 hold", res_out, held);
    end
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid reset", res_out, '0);
    check("R10 mid reset vld", {127'd0, out_vld}, '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule